// File: doc/BRIEF.md
# DPLL Operating-Mode Controller

This block decides which operating mode a telecom digital PLL runs in. It holds one of five states: reset, free-run, normal, holdover and auto-holdover. It moves between them from three things: a two-bit mode request from the system controller, a reference-select bit, and an ok/bad status bit from the reference-quality monitor. The loop filter and oscillator follow a two-bit loop-mode code that the block drives. That code tells them to halt, free-run on the local oscillator, track the reference, or freeze the last frequency.

The block takes some transitions on its own. If the tracked reference goes bad, it drops into auto-holdover. Once the reference recovers, it returns to normal without help, or, when automatic return is disabled, on a rising edge of a manual-return strobe. It never enters normal while the reference reads bad. After reset is released, a fixed initialization interval runs first; it is 625 µs at the default parameter and a 125 MHz clock. Every input is registered once inside the block, and select and strobe edges are found from the registered copies.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `lock_o` and `holdover_o` read 0 and `loop_mode_o` reads 2'b00 (halt), whatever the other inputs do.
- R2: After `rst_n` rises, the block stays in reset for exactly `INIT_CYCLES` rising clock edges and leaves it at the `INIT_CYCLES`-th edge. The mode request is ignored during that interval.
- R3: On leaving initialization, the block enters auto-holdover if the mode request is 2'b00 (normal) and the reference reads bad. Otherwise it enters free-run.
- R4: Mode request 2'b10 moves the block to free-run from any operating state.
- R5: Mode request 2'b01 moves the block to holdover from any operating state.
- R6: Under mode request 2'b00, any change of `ref_sel` moves the block from normal or auto-holdover into holdover. It also keeps the block in holdover for that cycle.
- R7: Under mode request 2'b00, free-run moves to holdover. Holdover moves to normal only while the reference reads ok; the block never enters normal with a bad reference.
- R8: In normal under mode request 2'b00, a bad reference moves the block to auto-holdover.
- R9: Auto-holdover returns to normal under mode request 2'b00 once the reference reads ok. With `auto_ret_dis` = 0 this needs nothing else. With `auto_ret_dis` = 1 it also needs a 0-to-1 edge on `man_ret`.
- R10: Mode request 2'b11 keeps the current state unchanged, whatever the reference and select inputs do.
- R11: `lock_o` is 1 only in normal. `holdover_o` is 1 in holdover and in auto-holdover. `loop_mode_o` reads 2'b01 in free-run, 2'b10 in normal and 2'b11 in both holdover states.
- R12: An input change that causes a transition shows at the outputs after the second rising clock edge following it: one edge to sample it, one to change state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode request: 00 normal, 01 holdover, 10 free-run, 11 keep |
| ref_sel | input | 1 | Reference select; any change is an event |
| ref_ok | input | 1 | Selected reference quality, 1 = ok |
| auto_ret_dis | input | 1 | 1 = leaving auto-holdover needs the manual strobe |
| man_ret | input | 1 | Manual-return strobe, rising edge counts |
| lock_o | output | 1 | Locked (normal state) |
| holdover_o | output | 1 | Holdover or auto-holdover |
| loop_mode_o | output | 2 | 00 halt, 01 free-run, 10 track, 11 freeze |

## Verification
The assertions check the single-step transition rules on every cycle. These are the forced moves to free-run and holdover, the hold under mode 11, entry into auto-holdover on a bad reference, and the refusal to leave auto-holdover without the strobe when automatic return is disabled. They also check that normal is only entered from a cycle in which the reference read ok, and that the init counter stays within its bound. Only the bench's scenarios can show the multi-step paths and the exact latency at the ports. These include free-run through holdover to normal, reset-exit decisions, the manual-strobe recovery, and that reset masks mode requests for the whole init interval.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_FREE  = 3'd1,
        ST_NORM  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_AUTO  = 3'd4
    } dmc_state_e;

    typedef enum logic [1:0] {
        LM_HALT   = 2'b00,
        LM_FREE   = 2'b01,
        LM_TRACK  = 2'b10,
        LM_FREEZE = 2'b11
    } loop_mode_e;

    localparam logic [1:0] MS_NORMAL = 2'b00;
    localparam logic [1:0] MS_HOLD   = 2'b01;
    localparam logic [1:0] MS_FREE   = 2'b10;
    localparam logic [1:0] MS_KEEP   = 2'b11;

    typedef struct packed {
        logic [1:0] ms;
        logic       rsel;
        logic       rsel_prev;
        logic       ok;
        logic       dis;
        logic       mhr;
        logic       mhr_prev;
    } ctl_regs_t;

    typedef struct packed {
        dmc_state_e st;
    } fsm_regs_t;

endpackage

// File: rtl/dmc_ctl_sample.sv
module dmc_ctl_sample
    import dmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       ref_sel,
    input  logic       ref_ok,
    input  logic       auto_ret_dis,
    input  logic       man_ret,
    output logic [1:0] ms_o,
    output logic       ok_o,
    output logic       dis_o,
    output logic       rsel_chg_o,
    output logic       mhr_rise_o
);

    ctl_regs_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.ms        = mode_sel;
        r_d.rsel      = ref_sel;
        r_d.rsel_prev = r_q.rsel;
        r_d.ok        = ref_ok;
        r_d.dis       = auto_ret_dis;
        r_d.mhr       = man_ret;
        r_d.mhr_prev  = r_q.mhr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ms_o       = r_q.ms;
    assign ok_o       = r_q.ok;
    assign dis_o      = r_q.dis;
    assign rsel_chg_o = r_q.rsel ^ r_q.rsel_prev;
    assign mhr_rise_o = r_q.mhr & ~r_q.mhr_prev;

    // R12: the sampled mode request is the port value one edge earlier
    a_r12_ms_sampled : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ms_o == $past(mode_sel)));

endmodule

// File: rtl/dmc_init_timer.sv
module dmc_init_timer #(
    parameter int INIT_CYCLES = 78125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done_o
);

    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run && (cnt_q != LAST)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LAST);

    // R2: the init count never passes its terminal value
    a_r2_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/dmc_fsm_core.sv
module dmc_fsm_core
    import dmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ms,
    input  logic       ok,
    input  logic       dis,
    input  logic       rsel_chg,
    input  logic       mhr_rise,
    input  logic       init_done,
    output logic       in_reset_o,
    output logic       lock_o,
    output logic       holdover_o,
    output logic [1:0] loop_mode_o
);

    fsm_regs_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (f_q.st == ST_RESET) begin
            if (init_done)
                f_d.st = (ms == MS_NORMAL && !ok) ? ST_AUTO : ST_FREE;
        end else begin
            case (ms)
                MS_FREE: f_d.st = ST_FREE;
                MS_HOLD: f_d.st = ST_HOLD;
                MS_KEEP: f_d.st = f_q.st;
                default: begin
                    case (f_q.st)
                        ST_FREE: f_d.st = ST_HOLD;
                        ST_HOLD: if (!rsel_chg && ok) f_d.st = ST_NORM;
                        ST_NORM: begin
                            if (rsel_chg)  f_d.st = ST_HOLD;
                            else if (!ok)  f_d.st = ST_AUTO;
                        end
                        ST_AUTO: begin
                            if (rsel_chg)                      f_d.st = ST_HOLD;
                            else if (ok && (!dis || mhr_rise)) f_d.st = ST_NORM;
                        end
                        default: f_d.st = f_q.st;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_RESET};
        else        f_q <= f_d;
    end

    always_comb begin
        in_reset_o = (f_q.st == ST_RESET);
        lock_o     = (f_q.st == ST_NORM);
        holdover_o = (f_q.st == ST_HOLD) || (f_q.st == ST_AUTO);
        case (f_q.st)
            ST_FREE:         loop_mode_o = LM_FREE;
            ST_NORM:         loop_mode_o = LM_TRACK;
            ST_HOLD, ST_AUTO: loop_mode_o = LM_FREEZE;
            default:         loop_mode_o = LM_HALT;
        endcase
    end

    // R2: no exit from reset before the init timer finishes
    a_r2_init_wait : assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_RESET && !init_done) |=> (f_q.st == ST_RESET));
    // R4
    a_r4_force_free : assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st != ST_RESET && ms == MS_FREE) |=> (f_q.st == ST_FREE));
    // R5
    a_r5_force_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st != ST_RESET && ms == MS_HOLD) |=> (f_q.st == ST_HOLD));
    // R6
    a_r6_sel_to_hold : assert property (@(posedge clk) disable iff (!rst_n)
        ((f_q.st == ST_NORM || f_q.st == ST_AUTO) && ms == MS_NORMAL && rsel_chg)
        |=> (f_q.st == ST_HOLD));
    // R7: normal is only entered after a cycle with a good reference
    a_r7_norm_needs_ok : assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_NORM && $past(f_q.st) != ST_NORM) |-> $past(ok));
    // R8
    a_r8_fail_to_auto : assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_NORM && ms == MS_NORMAL && !rsel_chg && !ok)
        |=> (f_q.st == ST_AUTO));
    // R9: with return disabled, no strobe edge means no return
    a_r9_manual_gate : assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_AUTO && ms == MS_NORMAL && !rsel_chg && dis && !mhr_rise)
        |=> (f_q.st == ST_AUTO));
    // R10
    a_r10_keep : assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st != ST_RESET && ms == MS_KEEP) |=> $stable(f_q.st));

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl #(
    parameter int INIT_CYCLES = 78125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       ref_sel,
    input  logic       ref_ok,
    input  logic       auto_ret_dis,
    input  logic       man_ret,
    output logic       lock_o,
    output logic       holdover_o,
    output logic [1:0] loop_mode_o
);

    logic [1:0] ms_s;
    logic       ok_s, dis_s, rsel_chg_s, mhr_rise_s;
    logic       in_reset, init_done;

    dmc_ctl_sample u_sample (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .ref_sel      (ref_sel),
        .ref_ok       (ref_ok),
        .auto_ret_dis (auto_ret_dis),
        .man_ret      (man_ret),
        .ms_o         (ms_s),
        .ok_o         (ok_s),
        .dis_o        (dis_s),
        .rsel_chg_o   (rsel_chg_s),
        .mhr_rise_o   (mhr_rise_s)
    );

    dmc_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_reset),
        .done_o (init_done)
    );

    dmc_fsm_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ms          (ms_s),
        .ok          (ok_s),
        .dis         (dis_s),
        .rsel_chg    (rsel_chg_s),
        .mhr_rise    (mhr_rise_s),
        .init_done   (init_done),
        .in_reset_o  (in_reset),
        .lock_o      (lock_o),
        .holdover_o  (holdover_o),
        .loop_mode_o (loop_mode_o)
    );

    // R11: lock and holdover never read 1 together, checked at the ports
    a_r11_excl : assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_o && holdover_o));
    // R11: lock implies the track code
    a_r11_lock_track : assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> (loop_mode_o == 2'b10));

endmodule

// File: tb/dpll_mode_ctrl_tb_top.sv
module dpll_mode_ctrl_tb_top;

    localparam int INIT = 16;
    // bench state numbering: 0 reset, 1 free-run, 2 normal, 3 holdover, 4 auto-holdover

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b10;
    logic       ref_sel = 1'b0;
    logic       ref_ok = 1'b0;
    logic       auto_ret_dis = 1'b0;
    logic       man_ret = 1'b0;
    logic       lock_o, holdover_o;
    logic [1:0] loop_mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dpll_mode_ctrl #(.INIT_CYCLES(INIT)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .ref_sel      (ref_sel),
        .ref_ok       (ref_ok),
        .auto_ret_dis (auto_ret_dis),
        .man_ret      (man_ret),
        .lock_o       (lock_o),
        .holdover_o   (holdover_o),
        .loop_mode_o  (loop_mode_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int st);
        logic       el, eh;
        logic [1:0] em;
        el = (st == 2);
        eh = (st == 3) || (st == 4);
        case (st)
            1:       em = 2'b01;
            2:       em = 2'b10;
            3, 4:    em = 2'b11;
            default: em = 2'b00;
        endcase
        n_chk++;
        if (lock_o !== el || holdover_o !== eh || loop_mode_o !== em) begin
            n_bad++;
            $display("FAIL %s: lock/hold/mode = %b/%b/%b expected %b/%b/%b",
                     req, lock_o, holdover_o, loop_mode_o, el, eh, em);
        end
    endtask

    function automatic int step_model(input int st, input logic [1:0] m, input bit ok);
        if (m == 2'b10) return 1;
        if (m == 2'b01) return 3;
        if (m == 2'b11) return st;
        case (st)
            1: return 3;
            3: return ok ? 2 : 3;
            2: return ok ? 2 : 4;
            4: return ok ? 2 : 4;
            default: return st;
        endcase
    endfunction

    function automatic int settle_model(input int st, input logic [1:0] m, input bit ok);
        int s = st;
        for (int i = 0; i < 4; i++) s = step_model(s, m, ok);
        return s;
    endfunction

    task automatic do_reset(input logic [1:0] ms, input bit ok, input int exp_exit);
        @(negedge clk);
        rst_n = 1'b0;
        mode_sel = ms;
        ref_ok = ok;
        man_ret = 1'b0;
        #1;
        chk("R1 reset asserted", 0);
        tick(3);
        chk("R1 held in reset", 0);
        rst_n = 1'b1;
        tick(INIT - 1);
        chk("R2 init not yet done", 0);
        tick(1);
        chk("R3 init exit state", exp_exit);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R2 with a mode request glitch during init, then R3 bad-ref exit
        @(negedge clk);
        rst_n = 1'b0;
        mode_sel = 2'b00;
        ref_ok = 1'b0;
        tick(2);
        chk("R1 outputs in reset", 0);
        rst_n = 1'b1;
        tick(3);
        mode_sel = 2'b10;
        tick(4);
        chk("R2 mode request ignored in init", 0);
        mode_sel = 2'b00;
        tick(INIT - 8);
        chk("R2 still initializing", 0);
        tick(1);
        chk("R3 exit to auto-holdover on bad ref", 4);

        // R9 automatic return, R12 exact latency
        auto_ret_dis = 1'b0;
        ref_ok = 1'b1;
        tick(1);
        chk("R12 one edge: no change yet", 4);
        tick(1);
        chk("R9 auto return to normal", 2);

        // R8 with exact latency
        ref_ok = 1'b0;
        tick(1);
        chk("R12 fail seen after one edge only", 2);
        tick(1);
        chk("R8 bad ref to auto-holdover", 4);

        // R9 manual return
        auto_ret_dis = 1'b1;
        ref_ok = 1'b1;
        tick(5);
        chk("R9 no return without strobe", 4);
        man_ret = 1'b1;
        tick(1);
        chk("R9 strobe sampled only", 4);
        tick(1);
        chk("R9 strobe edge returns to normal", 2);
        tick(3);
        chk("R9 steady strobe level keeps normal", 2);
        man_ret = 1'b0;
        auto_ret_dis = 1'b0;

        // R6 select change in normal, then R7 return
        ref_sel = ~ref_sel;
        tick(2);
        chk("R6 select change in normal", 3);
        tick(1);
        chk("R7 holdover to normal with good ref", 2);

        // R6 in auto-holdover, R7 refusal while ref bad
        ref_ok = 1'b0;
        tick(3);
        chk("R8 auto-holdover again", 4);
        ref_sel = ~ref_sel;
        tick(3);
        chk("R6 select change in auto-holdover", 3);
        tick(5);
        chk("R7 refuses normal with bad ref", 3);
        ref_ok = 1'b1;
        tick(3);
        chk("R7 normal once ref ok", 2);

        // R10 keep
        mode_sel = 2'b11;
        ref_ok = 1'b0;
        ref_sel = ~ref_sel;
        tick(5);
        chk("R10 keep state under 11", 2);
        mode_sel = 2'b00;
        tick(3);
        chk("R8 after keep released", 4);

        // R3 other exits
        ref_sel = 1'b0;
        do_reset(2'b01, 1'b0, 1);
        tick(1);
        chk("R5 holdover after free-run exit", 3);
        do_reset(2'b00, 1'b1, 1);
        tick(1);
        chk("R7 free-run to holdover", 3);
        tick(1);
        chk("R7 holdover to normal", 2);

        // R1 mid-operation reset
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset in normal", 0);

        // near-exhaustive sweep: start state x mode request (R4 R5 R10 R11)
        for (int s = 1; s <= 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                bit okv;
                do_reset(2'b10, 1'b1, 1);
                if (s >= 2) begin mode_sel = 2'b00; tick(4); end
                if (s == 3) begin mode_sel = 2'b01; tick(4); end
                if (s == 4) begin ref_ok = 1'b0; tick(4); end
                chk("R11 sweep start state", s);
                okv = ref_ok;
                mode_sel = 2'(m);
                tick(4);
                chk($sformatf("R4 R5 R10 sweep from %0d with mode %0d", s, m),
                    settle_model(s, 2'(m), okv));
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule